// File: doc/BRIEF.md
# Streaming Sobel Edge Detector

This block sits in a raster video path and marks the pixels that lie on an edge. Pixels arrive one per clock as 30-bit RGB words. A qualifier input is high for active pixels and low during blanking. The block keeps two full lines plus three pixels of history. From that history it takes a 3x3 neighbourhood and reduces each of the nine pixels to a luminance value using only shifts and adds. It then runs a vertical-edge kernel and a horizontal-edge kernel over the luminance grid.

An edge is reported when the magnitude of either gradient reaches a threshold. Software or panel controls load the threshold through a strobe. The centre pixel of the window is delayed along with the computation, so the colour word and its edge flag leave the block together. A later stage can then replace edge pixels with black.

Every register in the pipeline advances only on cycles where the qualifier is high. Latency is therefore counted in active pixels, not in clocks. Upstream timing must request pixels early by that latency.

Top module: `edge_stream_sobel`

## Requirements
- R1: While the active-low reset is asserted, and on the first clock after its release, the edge flag reads 0, the output pixel reads 0 and the stored threshold is 0. With a threshold of 0, every window is flagged.
- R2: The threshold register takes `thr_in_i` only on a clock where `thr_ld_i` is high. At all other times it keeps its value, whatever `thr_in_i` does.
- R3: The luminance of a pixel {red[29:20], green[19:10], blue[9:0]} is (red>>2) + (green>>1) + (blue>>2), with each term truncated separately. The sum never exceeds 1021 for 10-bit channels.
- R4: Window tap (row, col) is the pixel accepted row*LINE_W + col active pixels before the newest one in the window. Rows and columns run 0 to 2, with row 0 and col 0 the newest. The vertical-edge sum is (L00 + 2·L10 + L20) − (L02 + 2·L12 + L22). The horizontal-edge sum is (L00 + 2·L01 + L02) − (L20 + 2·L21 + L22).
- R5: Each sum is made non-negative by choosing between the signed sum and its negation. A direction hits when that magnitude is greater than or equal to the threshold, so equality counts as a hit.
- R6: The edge flag is the OR of the vertical-direction hit and the horizontal-direction hit.
- R7: The pixel accepted on the j-th active clock appears on `pix_o` after the (j+LINE_W+3)-th active clock. It appears together with the edge flag of the window centred on it. The window centre is tap (1,1).
- R8: On a clock where `valid_i` is low, nothing shifts and nothing is computed. `edge_o` and `pix_o` keep their values.
- R9: Internal sums hold ±4·1021 without wrapping. Full-scale black-to-white steps are therefore flagged for every threshold value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| valid_i | input | 1 | High for an active pixel, low during blanking |
| pix_i | input | 30 | Incoming pixel, red in the top 10 bits, blue in the bottom 10 |
| thr_ld_i | input | 1 | Strobe that captures a new threshold |
| thr_in_i | input | 10 | Threshold value presented for capture |
| pix_o | output | 30 | Centre pixel of the window, delayed to match the flag |
| edge_o | output | 1 | High when the forwarded pixel lies on an edge |

## Verification
The assertions expect reset to be held low from time zero until the clock is running. They also expect `valid_i`, `thr_ld_i` and the data inputs to change only between clock edges, so every sampled value is settled. The threshold strobe may arrive on any clock, active or blanking, and the checks on the threshold register allow for that. The stimulus changes inputs only on the falling edge and holds reset over the first cycles. It loads the threshold during blanking, presents a different value on `thr_in_i` without the strobe during each frame, and inserts blanking gaps inside frames to exercise the hold behaviour.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

  // Selects which gradient a kernel instance computes.
  typedef enum logic {
    GRAD_VERT = 1'b0,
    GRAD_HORZ = 1'b1
  } grad_dir_e;

  // Number of taps in the 3x3 neighbourhood.
  localparam int unsigned WIN_TAPS = 9;

  // Flat tap index of (row, col); row 0 / col 0 is the newest sample.
  function automatic int unsigned tap_idx(input int unsigned row, input int unsigned col);
    return row * 3 + col;
  endfunction

endpackage

// File: rtl/sobel_linebuf.sv
// History of two full lines plus three pixels, exposed as a 3x3 window.
module sobel_linebuf
  import sobel_pkg::*;
#(
  parameter int unsigned LINE_W = 640,
  parameter int unsigned PIX_W  = 30
) (
  input  logic                               clk,
  input  logic                               en,
  input  logic [PIX_W-1:0]                   pix_i,
  output logic [WIN_TAPS-1:0][PIX_W-1:0]     win_o,
  output logic [PIX_W-1:0]                   ctr_o
);

  localparam int unsigned DEPTH = 2 * LINE_W + 3;

  logic [PIX_W-1:0] chain_q [DEPTH];

  // R8: the chain moves only on active pixels. Contents are not reset.
  always_ff @(posedge clk) begin
    if (en) begin
      chain_q[0] <= pix_i;
      for (int i = 1; i < DEPTH; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  // R4: tap (row, col) sits row*LINE_W + col places behind the newest entry.
  for (genvar row = 0; row < 3; row++) begin : g_row
    for (genvar col = 0; col < 3; col++) begin : g_col
      assign win_o[row*3+col] = chain_q[row*LINE_W+col];
    end
  end

  // R7: the forwarded pixel is the window centre.
  assign ctr_o = chain_q[LINE_W+1];

endmodule

// File: rtl/sobel_luma.sv
// One registered shift-and-add luminance unit per window tap.
module sobel_luma
  import sobel_pkg::*;
#(
  parameter int unsigned CH_W = 10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 en,
  input  logic [WIN_TAPS-1:0][3*CH_W-1:0]      win_i,
  output logic [WIN_TAPS-1:0][CH_W-1:0]        luma_o
);

  logic [WIN_TAPS-1:0][CH_W-1:0] luma_d;
  logic [WIN_TAPS-1:0][CH_W-1:0] luma_q;

  // R3: quarter red + half green + quarter blue, each term truncated.
  for (genvar t = 0; t < WIN_TAPS; t++) begin : g_tap
    logic [CH_W-1:0] red, grn, blu;
    assign red = win_i[t][3*CH_W-1 -: CH_W];
    assign grn = win_i[t][2*CH_W-1 -: CH_W];
    assign blu = win_i[t][CH_W-1:0];
    assign luma_d[t] = (red >> 2) + (grn >> 1) + (blu >> 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      luma_q <= '0;
    end else if (en) begin
      luma_q <= luma_d;
    end
  end

  assign luma_o = luma_q;

endmodule

// File: rtl/sobel_grad.sv
// One gradient direction: weighted column/row difference, magnitude, compare.
module sobel_grad
  import sobel_pkg::*;
#(
  parameter int unsigned CH_W  = 10,
  parameter int unsigned THR_W = 10,
  parameter grad_dir_e   DIR   = GRAD_VERT
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  logic [WIN_TAPS-1:0][CH_W-1:0]   luma_i,
  input  logic [THR_W-1:0]                thr_i,
  output logic [CH_W+3:0]                 mag_o,
  output logic                            hit_o
);

  localparam int unsigned AW = CH_W + 2;   // weighted triple, unsigned
  localparam int unsigned SW = CH_W + 4;   // signed difference (R9)

  function automatic logic [AW-1:0] wsum(input logic [CH_W-1:0] a,
                                         input logic [CH_W-1:0] b,
                                         input logic [CH_W-1:0] c);
    return {2'b00, a} + {1'b0, b, 1'b0} + {2'b00, c};
  endfunction

  logic [AW-1:0] lead, trail;

  // R4: the parameter picks which triples are weighed against each other.
  if (DIR == GRAD_VERT) begin : g_vert
    assign lead  = wsum(luma_i[tap_idx(0,0)], luma_i[tap_idx(1,0)], luma_i[tap_idx(2,0)]);
    assign trail = wsum(luma_i[tap_idx(0,2)], luma_i[tap_idx(1,2)], luma_i[tap_idx(2,2)]);
  end else begin : g_horz
    assign lead  = wsum(luma_i[tap_idx(0,0)], luma_i[tap_idx(0,1)], luma_i[tap_idx(0,2)]);
    assign trail = wsum(luma_i[tap_idx(2,0)], luma_i[tap_idx(2,1)], luma_i[tap_idx(2,2)]);
  end

  logic signed [SW-1:0] diff, diff_neg;
  logic                 hit;
  logic                 flag_d, flag_q;

  // R5: both signs are formed; the non-negative one is compared.
  assign diff     = $signed({2'b00, lead}) - $signed({2'b00, trail});
  assign diff_neg = -diff;
  assign mag_o    = diff[SW-1] ? diff_neg : diff;
  assign hit      = (mag_o >= {{(SW-THR_W){1'b0}}, thr_i});

  // R8: the flag advances only with the stream.
  always_comb begin
    flag_d = flag_q;
    if (en) begin
      flag_d = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign hit_o = flag_q;

endmodule

// File: rtl/edge_stream_sobel.sv
// Top: window, luminance stage, two gradient units, threshold and centre delay.
module edge_stream_sobel
  import sobel_pkg::*;
#(
  parameter int unsigned LINE_W = 640,
  parameter int unsigned CH_W   = 10,
  parameter int unsigned THR_W  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [3*CH_W-1:0]    pix_i,
  input  logic                 thr_ld_i,
  input  logic [THR_W-1:0]     thr_in_i,
  output logic [3*CH_W-1:0]    pix_o,
  output logic                 edge_o
);

  localparam int unsigned PIX_W = 3 * CH_W;
  localparam int unsigned SW    = CH_W + 4;

  logic                              en;
  logic [WIN_TAPS-1:0][PIX_W-1:0]    win;
  logic [PIX_W-1:0]                  ctr;
  logic [WIN_TAPS-1:0][CH_W-1:0]     luma;
  logic [1:0][SW-1:0]                mag;
  logic [1:0]                        hit;

  logic [THR_W-1:0] thr_d, thr_q;
  logic [PIX_W-1:0] ctr_d1_d, ctr_d1_q;
  logic [PIX_W-1:0] pix_d, pix_q;

  // R8: blanking freezes every stage.
  assign en = valid_i;

  sobel_linebuf #(
    .LINE_W (LINE_W),
    .PIX_W  (PIX_W)
  ) u_linebuf (
    .clk    (clk),
    .en     (en),
    .pix_i  (pix_i),
    .win_o  (win),
    .ctr_o  (ctr)
  );

  sobel_luma #(
    .CH_W   (CH_W)
  ) u_luma (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .win_i  (win),
    .luma_o (luma)
  );

  for (genvar d = 0; d < 2; d++) begin : g_dir
    sobel_grad #(
      .CH_W  (CH_W),
      .THR_W (THR_W),
      .DIR   ((d == 0) ? GRAD_VERT : GRAD_HORZ)
    ) u_grad (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .luma_i (luma),
      .thr_i  (thr_q),
      .mag_o  (mag[d]),
      .hit_o  (hit[d])
    );
  end

  // R2: the threshold moves only on the load strobe.
  always_comb begin
    thr_d = thr_q;
    if (thr_ld_i) begin
      thr_d = thr_in_i;
    end
  end

  // R7: the centre pixel is delayed by two active stages to match the flag.
  always_comb begin
    ctr_d1_d = ctr_d1_q;
    pix_d    = pix_q;
    if (en) begin
      ctr_d1_d = ctr;
      pix_d    = ctr_d1_q;
    end
  end

  // R1: threshold and output path clear on reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q    <= '0;
      ctr_d1_q <= '0;
      pix_q    <= '0;
    end else begin
      thr_q    <= thr_d;
      ctr_d1_q <= ctr_d1_d;
      pix_q    <= pix_d;
    end
  end

  // R6: either direction marks the pixel.
  assign edge_o = |hit;
  assign pix_o  = pix_q;

endmodule

// File: rtl/edge_stream_sobel_chk.sv
// Temporal checks bound onto the top module.
module edge_stream_sobel_chk #(
  parameter int unsigned CH_W  = 10,
  parameter int unsigned THR_W = 10
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      valid_i,
  input logic                      thr_ld_i,
  input logic [THR_W-1:0]          thr_in_i,
  input logic [THR_W-1:0]          thr_q,
  input logic                      edge_o,
  input logic [3*CH_W-1:0]         pix_o,
  input logic [8:0][CH_W-1:0]      luma,
  input logic [1:0][CH_W+3:0]      mag
);

  localparam int unsigned SW   = CH_W + 4;
  localparam int unsigned CMAX = (1 << CH_W) - 1;
  localparam logic [CH_W-1:0] LMAX   = CH_W'((CMAX >> 2) * 2 + (CMAX >> 1));
  localparam logic [SW-1:0]   MAGMAX = SW'(4 * ((CMAX >> 2) * 2 + (CMAX >> 1)));

  // R1
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!edge_o && pix_o == '0 && thr_q == '0))
    else $error("R1 outputs or threshold not cleared by reset");

  // R2
  a_r2_thr_load: assert property (@(posedge clk) disable iff (!rst_n)
    thr_ld_i |=> (thr_q == $past(thr_in_i)))
    else $error("R2 threshold not captured on strobe");

  // R2
  a_r2_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_ld_i |=> $stable(thr_q))
    else $error("R2 threshold changed without strobe");

  // R8
  a_r8_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(edge_o) && $stable(pix_o)))
    else $error("R8 output moved during blanking");

  // R3
  for (genvar t = 0; t < 9; t++) begin : g_luma
    a_r3_luma_range: assert property (@(posedge clk) disable iff (!rst_n)
      luma[t] <= LMAX)
      else $error("R3 luminance above its ceiling");
  end

  // R9
  for (genvar d = 0; d < 2; d++) begin : g_mag
    a_r9_mag_range: assert property (@(posedge clk) disable iff (!rst_n)
      mag[d] <= MAGMAX)
      else $error("R9 gradient magnitude out of range");
  end

endmodule

bind edge_stream_sobel edge_stream_sobel_chk #(
  .CH_W  (CH_W),
  .THR_W (THR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_i  (valid_i),
  .thr_ld_i (thr_ld_i),
  .thr_in_i (thr_in_i),
  .thr_q    (thr_q),
  .edge_o   (edge_o),
  .pix_o    (pix_o),
  .luma     (luma),
  .mag      (mag)
);

// File: tb/test_edge_stream_sobel.sv
module test_edge_stream_sobel;

  localparam int W     = 16;
  localparam int H     = 8;
  localparam int NP    = W * H;
  localparam int CH    = 10;
  localparam int PW    = 3 * CH;
  localparam int THR_W = 10;

  // Case table: {threshold, pattern, blanking gaps}.
  // Patterns: 0 vertical step, 1 horizontal step, 2 hashed noise, 3 flat grey,
  // 4 full-scale vertical step.
  localparam int NCASE = 9;
  localparam int CASES [NCASE][3] = '{
    '{400,  0, 0},   // R5 equality: step magnitude is exactly 400
    '{401,  0, 0},   // R5 just above: no hits
    '{400,  1, 0},   // R4 horizontal kernel
    '{0,    3, 0},   // R5 zero magnitude reaches a zero threshold
    '{1,    3, 1},   // R8 flat field with blanking gaps
    '{300,  2, 0},   // R3 R6 noise
    '{700,  2, 1},   // R8 noise with gaps
    '{1023, 2, 0},   // R5 top threshold
    '{1023, 4, 0}    // R9 full-scale step
  };

  logic            clk;
  logic            rst_n;
  logic            valid_i;
  logic [PW-1:0]   pix_i;
  logic            thr_ld_i;
  logic [THR_W-1:0] thr_in_i;
  logic [PW-1:0]   pix_o;
  logic            edge_o;

  int nvec;
  int nerr;

  edge_stream_sobel #(
    .LINE_W (W),
    .CH_W   (CH),
    .THR_W  (THR_W)
  ) i_edge_stream_sobel (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .pix_i    (pix_i),
    .thr_ld_i (thr_ld_i),
    .thr_in_i (thr_in_i),
    .pix_o    (pix_o),
    .edge_o   (edge_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Synthetic frame source, indexed by stream position.
  function automatic logic [PW-1:0] gen(input int pat, input int n);
    int x;
    int y;
    logic [31:0] hv;
    x  = n % W;
    y  = (n / W) % H;
    hv = 32'(n) * 32'd1103515245 + 32'd12345;
    hv = hv ^ (hv >> 13);
    case (pat)
      0:       return (x < W/2) ? {10'd100, 10'd100, 10'd100} : {10'd200, 10'd200, 10'd200};
      1:       return (y < H/2) ? {10'd100, 10'd100, 10'd100} : {10'd200, 10'd200, 10'd200};
      2:       return hv[29:0];
      3:       return {10'd512, 10'd300, 10'd77};
      default: return (x < W/2) ? 30'd0 : {30{1'b1}};
    endcase
  endfunction

  function automatic int lum(input logic [PW-1:0] p);
    return int'(p[29:20] >> 2) + int'(p[19:10] >> 1) + int'(p[9:0] >> 2);
  endfunction

  // Expected flag for the window whose newest pixel is stream index m.
  function automatic logic ref_flag(input int pat, input int m, input int thr);
    int l [3][3];
    int gx;
    int gy;
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) begin
        l[r][c] = lum(gen(pat, m - r*W - c));
      end
    end
    gx = (l[0][0] + 2*l[1][0] + l[2][0]) - (l[0][2] + 2*l[1][2] + l[2][2]);
    gy = (l[0][0] + 2*l[0][1] + l[0][2]) - (l[2][0] + 2*l[2][1] + l[2][2]);
    if (gx < 0) gx = -gx;
    if (gy < 0) gy = -gy;
    return (gx >= thr) || (gy >= thr);
  endfunction

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_pix(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Streams one frame. The threshold is loaded during blanking when asked;
  // afterwards a different value sits on thr_in_i without the strobe (R2).
  task automatic run_frame(input bit do_load, input int thr, input int pat, input bit gaps);
    int k;
    int slot;
    int m;
    bit v;
    logic pe;
    logic [PW-1:0] pp;
    @(negedge clk);
    valid_i = 1'b0;
    if (do_load) begin
      thr_in_i = thr[THR_W-1:0];
      thr_ld_i = 1'b1;
      @(negedge clk);
    end
    thr_ld_i = 1'b0;
    thr_in_i = ~thr[THR_W-1:0];
    @(negedge clk);
    pe = edge_o;
    pp = pix_o;
    k = 0;
    slot = 0;
    while (k < NP) begin
      v = !(gaps && (slot % 3 == 2));
      slot++;
      valid_i = v;
      pix_i   = v ? gen(pat, k) : gen(2, slot + 5000);
      @(negedge clk);
      if (v) begin
        k++;
        if (k >= 2*W + 5) begin
          m = k - 3;
          chk_bit($sformatf("R2 R4 R5 R6 flag pat=%0d thr=%0d k=%0d", pat, thr, k),
                  edge_o, ref_flag(pat, m, thr));
          chk_pix($sformatf("R7 centre pat=%0d k=%0d", pat, k),
                  pix_o, gen(pat, m - W - 1));
        end
      end else begin
        chk_bit($sformatf("R8 hold flag pat=%0d k=%0d", pat, k), edge_o, pe);
        chk_pix($sformatf("R8 hold pixel pat=%0d k=%0d", pat, k), pix_o, pp);
      end
      pe = edge_o;
      pp = pix_o;
    end
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    nvec     = 0;
    nerr     = 0;
    rst_n    = 1'b0;
    valid_i  = 1'b0;
    pix_i    = '0;
    thr_ld_i = 1'b0;
    thr_in_i = '0;
    repeat (4) @(negedge clk);
    chk_bit("R1 reset flag", edge_o, 1'b0);
    chk_pix("R1 reset pixel", pix_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R1 flag after release", edge_o, 1'b0);
    chk_pix("R1 pixel after release", pix_o, '0);

    // R1: threshold cleared to 0, so a flat frame is flagged everywhere.
    run_frame(1'b0, 0, 3, 1'b0);

    // Table walk.
    for (int i = 0; i < NCASE; i++) begin
      run_frame(1'b1, CASES[i][0], CASES[i][1], CASES[i][2] != 0);
    end

    // R2: no strobe, so the last loaded threshold (1023) still applies.
    run_frame(1'b0, 1023, 2, 1'b0);

    // R1: reset in the middle of a stream clears outputs and threshold.
    @(negedge clk);
    valid_i = 1'b1;
    for (int i = 0; i < 2*W + 8; i++) begin
      pix_i = gen(2, i);
      @(negedge clk);
    end
    valid_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk_bit("R1 mid-stream reset flag", edge_o, 1'b0);
    chk_pix("R1 mid-stream reset pixel", pix_o, '0);
    rst_n = 1'b1;
    run_frame(1'b0, 0, 1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule